// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between devices and memory without processor involvement. It has four channels. Each channel holds a 16-bit current address, a 16-bit current count and a mode. A host register port programs these values and also sets a channel mask, software requests and a global disable. A device asks for service by raising its request line. The controller then requests the system bus with `hold_req` and waits for `hold_ack`. Once it owns the bus, it issues one transfer per cycle. Each transfer drives the memory address, one read or write strobe and the served channel's acknowledge. The data path itself is not modelled; only the address and the strobes are.

Each channel's mode sets the termination rule:
- **Single:** one transfer per bus grant.
- **Block:** transfers continue until terminal count or an external end-of-process pulse.
- **Demand:** as block, but the burst also stops when the channel's request drops.

At terminal count, a channel either reloads its programmed start values (auto-initialize) or masks itself. A sticky per-channel flag records the terminal count until the host reads it.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, `hold_req`, `mem_rd`, `mem_wr`, `tc` and `dack` are low. The mask register reads 4'hF (all channels masked) and the status register reads 0.
- R2: An unmasked pending channel raises `hold_req`. No strobe appears before `hold_ack` is high. During each transfer, `dack` is one-hot on the channel being served and zero otherwise.
- R3: Each transfer uses the current address, then steps it by +1, or by -1 when mode bit 3 is set. The step wraps modulo 2^16. The current address reads back after a transfer.
- R4: A programmed count N gives N+1 transfers. `tc` is high only during the last transfer of a run, the one in which the count is 0.
- R5: Mode bit 2 = 1 gives `mem_wr` strobes (device to memory). Mode bit 2 = 0 gives `mem_rd`. The two are never high together.
- R6: Mode bits [1:0] = 0 (single) give one transfer per grant. `hold_req` drops between transfers.
- R7: Mode bits [1:0] = 1 (block) keep the bus and transfer on consecutive cycles until terminal count. An `eop` pulse seen during a transfer ends the run after that transfer, without setting the terminal-count flag.
- R8: Mode bits [1:0] = 2 (demand) run like block mode. They also end after the transfer in which the channel's request (hardware or software) is low. The remaining count reads back.
- R9: At terminal count, a channel with mode bit 4 set reloads its programmed address and count and stays unmasked. Without bit 4, its mask bit is set.
- R10: Among pending channels, the lowest-numbered one is served first.
- R11: A masked channel's request is ignored. Writing a 1 to a request-register bit starts that channel without a device request. The bit clears at terminal count or `eop`. Command bit 0 = 1 blocks all new service.
- R12: Status bits [3:0] hold one sticky terminal-count flag per channel. A status read returns the flags and clears them at the end of that read cycle.
- R13: Register map. `reg_addr[3:2]` selects the group:
  - 0: address of channel `reg_addr[1:0]`
  - 1: count of that channel
  - 2: mode of that channel
  - 3: control, where `reg_addr[1:0]` selects 0 = mask, 1 = request, 2 = command, 3 = status

  Writing the address or count sets both the current value and the reload copy. Reads of groups 0 and 1 return the current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (clears status) |
| reg_addr | input | 4 | Host register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from `reg_addr` |
| dreq | input | 4 | Device request per channel |
| dack | output | 4 | Device acknowledge per channel |
| eop | input | 1 | External end-of-process |
| hold_req | output | 1 | System bus request |
| hold_ack | input | 1 | System bus grant |
| mem_addr | output | 16 | Memory address during a transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal count on the final transfer |

## Verification
The timing from request to transfer is as follows:
- `hold_req` rises in the cycle after the edge that first sees an unmasked request.
- The first strobe comes in the cycle after the edge that samples `hold_ack`.
- Block and demand transfers then follow on consecutive cycles, and the mask, status and request updates land on the edge that ends the final transfer.

Register reads are combinational and are sampled in the same cycle. A status read clears the flags on the edge that closes it.

The bench counts strobes, terminal counts and grants at every falling edge. It compares run totals only after the bus has been idle for eight cycles. For demand and end-of-process stimulus, it changes the input just after the falling edge of the n-th strobe, so that exactly n transfers are expected.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_BLOCK  = 2'd1,
    XM_DEMAND = 2'd2
  } xfer_mode_e;

  // bit4 reload at tc, bit3 count down, bit2 device-to-memory, bits1:0 mode
  typedef struct packed {
    logic       autoinit;
    logic       dec;
    logic       to_mem;
    xfer_mode_e xm;
  } chan_mode_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_MOVE = 2'd2
  } seq_st_e;

  localparam int unsigned MODE_W = $bits(chan_mode_t);

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_addr,
  input  logic         ld_cnt,
  input  logic         ld_mode,
  input  logic [W-1:0] wdata,
  input  logic         step,
  output logic [W-1:0] cur_addr,
  output logic [W-1:0] cur_cnt,
  output chan_mode_t   mode,
  output logic         at_tc
);

  logic [W-1:0] base_addr_q, base_cnt_q, addr_q, cnt_q, addr_d, cnt_d;
  chan_mode_t   mode_q;
  logic         addr_en, cnt_en;

  assign at_tc    = (cnt_q == '0);
  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign mode     = mode_q;
  assign addr_en  = ld_addr | step;
  assign cnt_en   = ld_cnt | step;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (ld_addr) begin
      addr_d = wdata;
    end else if (step) begin
      if (at_tc && mode_q.autoinit) addr_d = base_addr_q;
      else if (mode_q.dec)          addr_d = addr_q - 1'b1;
      else                          addr_d = addr_q + 1'b1;
    end
    if (ld_cnt) begin
      cnt_d = wdata;
    end else if (step) begin
      if (at_tc && mode_q.autoinit) cnt_d = base_cnt_q;
      else                          cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
      mode_q      <= '0;
    end else begin
      if (ld_addr) base_addr_q <= wdata;
      if (ld_cnt)  base_cnt_q  <= wdata;
      if (addr_en) addr_q      <= addr_d;
      if (cnt_en)  cnt_q       <= cnt_d;
      if (ld_mode) mode_q      <= chan_mode_t'(wdata[MODE_W-1:0]);
    end
  end

endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter  int unsigned NCH = 4,
  localparam int unsigned CHB = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend,
  output logic [CHB-1:0] pick,
  output logic           any
);

  assign any = |pend;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = CHB'(i);
    end
  end

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter  int unsigned NCH = 4,
  localparam int unsigned CHB = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend,
  input  logic           hold_ack,
  input  xfer_mode_e     xm,
  input  logic           at_tc,
  input  logic           req_live,
  input  logic           eop,
  output seq_st_e        st,
  output logic [CHB-1:0] act
);

  logic [CHB-1:0] pick;
  logic           any, act_en, fin;
  seq_st_e        st_d;

  dma4_prio #(.NCH(NCH)) prio_i (.pend(pend), .pick(pick), .any(any));

  always_comb begin
    unique case (xm)
      XM_SINGLE: fin = 1'b1;
      XM_DEMAND: fin = at_tc | eop | ~req_live;
      default:   fin = at_tc | eop;
    endcase
  end

  always_comb begin
    st_d   = st;
    act_en = 1'b0;
    unique case (st)
      SQ_IDLE: if (any) begin
        st_d   = SQ_HOLD;
        act_en = 1'b1;
      end
      SQ_HOLD: if (hold_ack) st_d = SQ_MOVE;
      SQ_MOVE: if (fin) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      act <= '0;
    end else begin
      st <= st_d;
      if (act_en) act <= pick;
    end
  end

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter  int unsigned NCH = 4,
  parameter  int unsigned W   = 16,
  localparam int unsigned CHB = $clog2(NCH),
  localparam int unsigned RAW = CHB + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  input  logic           eop,
  output logic           hold_req,
  input  logic           hold_ack,
  output logic [W-1:0]   mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           tc
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [1:0]     grp;
  logic [CHB-1:0] sel;
  logic           wr_ctl, wr_mask, wr_sreq, wr_cmd, rd_stat;
  assign grp     = reg_addr[RAW-1:CHB];
  assign sel     = reg_addr[CHB-1:0];
  assign wr_ctl  = reg_wr && (grp == 2'd3);
  assign wr_mask = wr_ctl && (sel == CHB'(0));
  assign wr_sreq = wr_ctl && (sel == CHB'(1));
  assign wr_cmd  = wr_ctl && (sel == CHB'(2));
  assign rd_stat = reg_rd && (grp == 2'd3) && (sel == CHB'(3));

  logic [W-1:0] ch_addr [NCH];
  logic [W-1:0] ch_cnt  [NCH];
  chan_mode_t   ch_mode [NCH];
  logic [NCH-1:0] ch_tc;

  seq_st_e        st;
  logic [CHB-1:0] act;
  logic           move, atc, req_live;
  chan_mode_t     amode;

  logic [NCH-1:0] mask_q, mask_d, sreq_q, sreq_d, tcf_q, tcf_d, pend;
  logic           dis_q;

  assign move     = (st == SQ_MOVE);
  assign amode    = ch_mode[act];
  assign atc      = ch_tc[act];
  assign req_live = dreq[act] | sreq_q[act];
  assign pend     = dis_q ? '0 : ((dreq | sreq_q) & ~mask_q);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = reg_wr && (sel == CHB'(g));
    dma4_chan #(.W(W)) chan_i (
      .clk      (clk),
      .rst_n    (rst_i),
      .ld_addr  (hit && (grp == 2'd0)),
      .ld_cnt   (hit && (grp == 2'd1)),
      .ld_mode  (hit && (grp == 2'd2)),
      .wdata    (reg_wdata),
      .step     (move && (act == CHB'(g))),
      .cur_addr (ch_addr[g]),
      .cur_cnt  (ch_cnt[g]),
      .mode     (ch_mode[g]),
      .at_tc    (ch_tc[g])
    );
  end

  dma4_seq #(.NCH(NCH)) seq_i (
    .clk      (clk),
    .rst_n    (rst_i),
    .pend     (pend),
    .hold_ack (hold_ack),
    .xm       (amode.xm),
    .at_tc    (atc),
    .req_live (req_live),
    .eop      (eop),
    .st       (st),
    .act      (act)
  );

  always_comb begin
    mask_d = mask_q;
    sreq_d = sreq_q;
    tcf_d  = tcf_q;
    if (wr_mask) mask_d = reg_wdata[NCH-1:0];
    if (wr_sreq) sreq_d = reg_wdata[NCH-1:0];
    if (rd_stat) tcf_d  = '0;
    if (move && (atc || eop)) sreq_d[act] = 1'b0;
    if (move && atc) begin
      tcf_d[act] = 1'b1;
      if (!amode.autoinit) mask_d[act] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mask_q <= '1;
      sreq_q <= '0;
      tcf_q  <= '0;
      dis_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      sreq_q <= sreq_d;
      tcf_q  <= tcf_d;
      if (wr_cmd) dis_q <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (grp)
      2'd0: reg_rdata = ch_addr[sel];
      2'd1: reg_rdata = ch_cnt[sel];
      2'd2: reg_rdata = {{(W - MODE_W){1'b0}}, ch_mode[sel]};
      default: begin
        if      (sel == CHB'(0)) reg_rdata = W'(mask_q);
        else if (sel == CHB'(1)) reg_rdata = W'(sreq_q);
        else if (sel == CHB'(2)) reg_rdata = W'(dis_q);
        else                     reg_rdata = W'(tcf_q);
      end
    endcase
  end

  always_comb begin
    dack = '0;
    if (move) dack[act] = 1'b1;
  end

  assign hold_req = (st != SQ_IDLE);
  assign mem_addr = move ? ch_addr[act] : '0;
  assign mem_rd   = move && !amode.to_mem;
  assign mem_wr   = move && amode.to_mem;
  assign tc       = move && atc;

endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_req,
  input logic           hold_ack,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [W-1:0]   mem_addr,
  input logic [NCH-1:0] dack,
  input logic           tc
);

  logic strobe;
  assign strobe = mem_rd | mem_wr;

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_strobe_needs_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (hold_req && hold_ack));

  assert_dack_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack) && ((dack != '0) == strobe));

  assert_no_strobe_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> !strobe);

  assert_tc_in_transfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> strobe);

  assert_addr_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe) && (dack == $past(dack)) && !$past(tc)) |->
      ((mem_addr == $past(mem_addr) + 1'b1) || (mem_addr == $past(mem_addr) - 1'b1)));

endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH), .W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold_req (hold_req),
  .hold_ack (hold_ack),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .dack     (dack),
  .tc       (tc)
);

// File: tb/dma4_ctrl_tb_top.sv
module dma4_ctrl_tb_top;

  localparam int NCH = 4;
  localparam int W   = 16;

  logic           clk = 1'b0;
  logic           rst_n, reg_wr, reg_rd, eop, hold_req, hold_ack, mem_rd, mem_wr, tc;
  logic [3:0]     reg_addr;
  logic [W-1:0]   reg_wdata, reg_rdata, mem_addr;
  logic [NCH-1:0] dreq, dack;

  always #5 clk = ~clk;

  dma4_ctrl #(.NCH(NCH), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack), .eop(eop),
    .hold_req(hold_req), .hold_ack(hold_ack), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .tc(tc)
  );

  // bus owner grants one cycle after the request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_ack <= 1'b0;
    else        hold_ack <= hold_req;
  end

  // monitor: cumulative counters, written only here
  int tot_x = 0, tot_tc = 0, tc_pos = 0, tot_g = 0, tot_wr = 0, bad_dack = 0;
  logic [W-1:0] alog [64];
  logic [W-1:0] last_a = '0;
  logic prev_h = 1'b0;
  int exp_ch = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_req && !prev_h) tot_g++;
      prev_h = hold_req;
      if (mem_rd || mem_wr) begin
        alog[tot_x % 64] = mem_addr;
        last_a = mem_addr;
        tot_x++;
        if (mem_wr) tot_wr++;
        if (tc) begin tot_tc++; tc_pos = tot_x; end
        if (dack != (4'b1 << exp_ch)) bad_dack++;
      end
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 8) begin
      @(negedge clk);
      q = hold_req ? 0 : q + 1;
    end
  endtask

  task automatic prog(input int ch, input logic [4:0] mode, input logic [W-1:0] a, input logic [W-1:0] c);
    wr({2'b00, 2'(ch)}, a);
    wr({2'b01, 2'(ch)}, c);
    wr({2'b10, 2'(ch)}, {11'd0, mode});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  // {ch[2], mode[5], start[16], count[16], n_xfer[16], last_addr[16], grants[8]}
  localparam int NV = 5;
  localparam logic [78:0] VEC [NV] = '{
    {2'd0, 5'b00101, 16'h1000, 16'd3, 16'd4, 16'h1003, 8'd1},  // block up, to memory
    {2'd1, 5'b01001, 16'h2000, 16'd2, 16'd3, 16'h1FFE, 8'd1},  // block down, from memory
    {2'd2, 5'b00000, 16'h0030, 16'd2, 16'd3, 16'h0032, 8'd3},  // single up
    {2'd3, 5'b00101, 16'h0500, 16'd0, 16'd1, 16'h0500, 8'd1},  // count 0: one item
    {2'd0, 5'b01101, 16'h0001, 16'd2, 16'd3, 16'hFFFF, 8'd1}   // down across zero
  };

  initial begin
    logic [W-1:0] d;
    int b_x, b_g, b_tc, b_wr, b_bd;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    dreq = '0; eop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "hold_req", hold_req, 0);
    chk("R1", "strobes", {mem_rd, mem_wr, tc}, 0);
    chk("R1", "dack", dack, 0);
    rd(4'hC, d); chk("R1", "mask", d, 16'h000F);
    rd(4'hF, d); chk("R1", "status", d, 0);

    // R11 masked requests are ignored
    dreq = 4'hF;
    repeat (10) @(negedge clk);
    chk("R11", "masked hold_req", hold_req, 0);
    chk("R11", "masked transfers", tot_x, 0);
    dreq = '0;

    // R13 vector table via register map, soft request start
    for (int v = 0; v < NV; v++) begin
      logic [78:0] t;
      int ch, en;
      t = VEC[v];
      ch = int'(t[78:77]);
      en = int'(t[39:24]);
      exp_ch = ch;
      prog(ch, t[76:72], t[71:56], t[55:40]);
      b_x = tot_x; b_g = tot_g; b_tc = tot_tc; b_wr = tot_wr; b_bd = bad_dack;
      wr(4'hC, 16'(~(4'b1 << ch) & 4'hF));
      wr(4'hD, 16'(4'b1 << ch));
      wait_quiet();
      chk("R4", "transfer count", tot_x - b_x, en);
      chk("R3", "first address", alog[b_x % 64], t[71:56]);
      chk("R3", "last address", last_a, t[23:8]);
      chk(t[73:72] == 2'd0 ? "R6" : "R7", "grants", tot_g - b_g, t[7:0]);
      chk("R4", "tc pulses", tot_tc - b_tc, 1);
      chk("R4", "tc on last", tc_pos, b_x + en);
      chk("R5", "write strobes", tot_wr - b_wr, t[74] ? en : 0);
      chk("R2", "dack mismatches", bad_dack - b_bd, 0);
      rd(4'hF, d); chk("R12", "status flag", d, 16'(4'b1 << ch));
      rd(4'hF, d); chk("R12", "status cleared", d, 0);
      rd(4'hC, d); chk("R9", "mask set at tc", d, 16'h000F);
    end

    // R11 command disable, then hardware request in single mode
    exp_ch = 1;
    prog(1, 5'b00000, 16'h0700, 16'd0);
    wr(4'hE, 16'd1);
    wr(4'hC, 16'h000D);
    b_x = tot_x;
    dreq = 4'b0010;
    repeat (10) @(negedge clk);
    chk("R11", "disabled transfers", tot_x - b_x, 0);
    wr(4'hE, 16'd0);
    wait_quiet();
    dreq = '0;
    chk("R11", "enabled transfers", tot_x - b_x, 1);
    chk("R3", "hw request address", last_a, 16'h0700);
    rd(4'hF, d);

    // R10 fixed priority between channels 1 and 2
    prog(1, 5'b00000, 16'h0A00, 16'd0);
    prog(2, 5'b00000, 16'h0B00, 16'd0);
    wr(4'hC, 16'h0009);
    dreq = 4'b0110;
    begin
      int guard = 0;
      @(negedge clk);
      while (!(mem_rd || mem_wr) && guard < 50) begin @(negedge clk); guard++; end
      chk("R10", "first served", dack, 4'b0010);
    end
    wait_quiet();
    dreq = '0;
    rd(4'hF, d); chk("R10", "both served", d, 16'h0006);

    // R8 demand mode stops when request drops
    exp_ch = 2;
    prog(2, 5'b00010, 16'h0300, 16'd9);
    wr(4'hC, 16'h000B);
    b_x = tot_x; b_tc = tot_tc;
    @(negedge clk); dreq = 4'b0100;
    begin
      int guard = 0;
      do begin @(negedge clk); #1; guard++; end while (tot_x - b_x < 3 && guard < 60);
    end
    dreq = '0;
    wait_quiet();
    chk("R8", "demand transfers", tot_x - b_x, 3);
    chk("R8", "demand no tc", tot_tc - b_tc, 0);
    rd(4'h6, d); chk("R8", "remaining count", d, 16'd6);
    rd(4'h2, d); chk("R3", "address readback", d, 16'h0303);

    // R7 end-of-process in block mode
    exp_ch = 3;
    prog(3, 5'b00101, 16'h0800, 16'd20);
    wr(4'hC, 16'h0007);
    b_x = tot_x;
    wr(4'hD, 16'h0008);
    begin
      int guard = 0;
      do begin @(negedge clk); #1; guard++; end while (tot_x - b_x < 2 && guard < 60);
    end
    eop = 1'b1;
    @(negedge clk); eop = 1'b0;
    wait_quiet();
    chk("R7", "eop transfers", tot_x - b_x, 2);
    rd(4'hF, d); chk("R7", "eop no tc flag", d, 0);
    rd(4'hD, d); chk("R11", "soft request cleared", d, 0);

    // R9 auto-initialize reload
    exp_ch = 0;
    prog(0, 5'b10101, 16'h0100, 16'd1);
    wr(4'hC, 16'h000E);
    b_x = tot_x;
    wr(4'hD, 16'h0001);
    wait_quiet();
    chk("R9", "autoinit transfers", tot_x - b_x, 2);
    rd(4'h0, d); chk("R9", "address reloaded", d, 16'h0100);
    rd(4'h4, d); chk("R9", "count reloaded", d, 16'd1);
    rd(4'hC, d); chk("R9", "mask kept clear", d, 16'h000E);
    rd(4'hF, d); chk("R12", "autoinit tc flag", d, 16'h0001);

    finish_run();
  end

endmodule